// File: doc/BRIEF.md
# Watchdog Timer with Tap-Selectable Prescaler

This block is the watchdog counter of a small microcontroller core. It counts ticks from one of two sources, chosen by a strap that stays fixed while the chip runs. One source is a slow free-running oscillator, brought into the system clock domain as a one-cycle enable. The other is the instruction rate, which is the system clock divided by four. The ticks drive a fixed base counter (8 bits by default) and then a 7-bit prescaler. A 3-bit select field in an 8-bit control register picks the prescaler tap whose overflow ends the time-out period. The other five bits of the register are flags that software can read and write and that have no effect on timing.

Software keeps the watchdog from expiring by issuing clear strobes. A strap selects the clear policy. Under the single policy, one clear strobe restarts the count. Under the paired policy, two separate strobes, A and B, must both be seen before the count restarts. Each of them is remembered until the other one arrives. Entering HALT also restarts the count, and so does the synchronous active-low reset. When the instruction rate is the source and the core is halted, counting freezes. When the oscillator is the source, counting goes on. An expiry while the core runs raises a one-cycle full-reset request. An expiry while the core is halted raises a one-cycle warm-wake request instead. A disable strap suppresses counting, clears and expiries.

Top module: `wdog_timer`

## Requirements
- R1: After reset, reg_rdata reads 8'h07 (select code 3'b111, flags zero), and both to_cold and to_warm are low.
- R2: With the instruction rate as source and select code k (reg bits 2:0), the first expiry pulse comes exactly 4 * 2^(BASE_BITS+k) system cycles after the clock edge that applies a clear.
- R3: With the oscillator as source, the expiry comes on the 2^(BASE_BITS+k)-th rising edge of osc_raw after a clear, within a few cycles of the synchronizer delay.
- R4: reg_rdata returns the last value written with reg_we. Bits 7:3 are flags and do not change the period.
- R5: Under the single policy (opt_dual_clr=0), a clr_one strobe restarts the count, and clr_a or clr_b alone or in sequence have no effect.
- R6: Under the paired policy (opt_dual_clr=1), clr_one and a lone clr_a or clr_b have no effect. The count restarts on the cycle that completes the pair, in either order or with both in the same cycle. An expiry does not drop a pending half.
- R7: A halt_req strobe restarts the count, whatever the clear policy.
- R8: With the instruction rate as source, cycles with halted=1 do not advance the count. With the oscillator as source, halted does not stop counting.
- R9: Every expiry is a single-cycle pulse, after which the count restarts from zero. It appears on to_cold if halted was low at the expiring tick and on to_warm if halted was high.
- R10: With opt_enable=0, neither to_cold nor to_warm ever pulses, under any clear or tick stimulus, and the register stays readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| opt_enable | input | 1 | Static strap: 1 enables the watchdog |
| opt_osc_src | input | 1 | Static strap: 1 selects the slow oscillator, 0 the instruction rate |
| opt_dual_clr | input | 1 | Static strap: 1 selects the paired clear policy |
| osc_raw | input | 1 | Asynchronous slow-oscillator square wave |
| halt_req | input | 1 | One-cycle strobe: the core enters HALT |
| halted | input | 1 | Level: the core is halted |
| clr_one | input | 1 | Single-policy clear strobe |
| clr_a | input | 1 | First half of the paired clear |
| clr_b | input | 1 | Second half of the paired clear |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | REG_BITS | Control register write data |
| reg_rdata | output | REG_BITS | Control register read-back |
| to_cold | output | 1 | Expiry pulse while running (full reset request) |
| to_warm | output | 1 | Expiry pulse while halted (warm wake request) |

## Verification
The bench sweeps all eight select codes for both tick sources and compares each period against 4*2^(B+k) cycles or 2^(B+k) oscillator edges. This catches an off-by-one tap, a wrongly counted divide-by-four phase, or a counter that does not restart after expiry. It checks that a lone half of the paired clear leaves the period untouched and that a half still pending across an expiry completes the pair later. A design that cleared on either strobe, or lost its pending bit, would show a shifted expiry. It freezes the instruction-rate count with halted held for thousands of cycles and expects exactly the remaining cycles afterwards, so a design that leaks ticks while halted expires early. It also checks that expiries raised while halted come out on the warm output only, and that the disable strap silences everything.

// File: rtl/wdog_pkg.sv
// Shared types for the watchdog block.
// Assumes: straps are static, so enum decodes are never re-timed.
package wdog_pkg;

    // Tick source selected by the static strap.
    typedef enum logic {
        SRC_INSTR = 1'b0,
        SRC_OSC   = 1'b1
    } tick_src_e;

    // Clear policy selected by the static strap.
    typedef enum logic {
        POLICY_SINGLE = 1'b0,
        POLICY_PAIR   = 1'b1
    } clr_policy_e;

endpackage

// File: rtl/wdog_tick_gen.sv
// Produces the one-cycle count enable for the watchdog chain.
// Oscillator mode: osc_raw goes through a SYNC_STAGES flop synchronizer
// and a rising-edge detector. Instruction mode: a DIV_BITS counter yields
// one tick every 2**DIV_BITS cycles and freezes while the core is halted.
// Assumes: osc_raw high and low phases each last more than SYNC_STAGES+1 cycles.
module wdog_tick_gen
    import wdog_pkg::*;
#(
    parameter int DIV_BITS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  tick_src_e src,
    input  logic      halted,
    input  logic      wd_clear,
    input  logic      osc_raw,
    output logic      tick
);

    logic [SYNC_STAGES:0]  sync_q;
    logic [DIV_BITS-1:0]   div_q;
    logic                  osc_pulse;
    logic                  instr_run;

    // Synchronizer and edge-history shift register for the slow oscillator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], osc_raw};
        end
    end

    assign osc_pulse = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign instr_run = enable && (src == SRC_INSTR) && !halted;

    // Instruction-rate phase counter, restarted with the watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n || wd_clear) begin
            div_q <= '0;
        end else if (instr_run) begin
            div_q <= div_q + 1'b1;
        end
    end

    // Select the enable pulse from the active source.
    always_comb begin
        if (src == SRC_OSC) begin
            tick = enable & osc_pulse;
        end else begin
            tick = instr_run & (&div_q);
        end
    end

    // R8: instruction-rate ticks never occur while the core is halted.
    p_halt_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_INSTR && halted) |-> !tick);

    // R8: the phase counter holds while halted on the instruction rate.
    p_halt_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_INSTR && halted && !wd_clear) |=> $stable(div_q));

    // R10: no tick leaves this block while disabled.
    p_disabled_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tick);

endmodule

// File: rtl/wdog_clear_ctl.sv
// Merges the clear sources into one watchdog clear strobe.
// Single policy: clr_one clears. Paired policy: clr_a and clr_b each set a
// pending bit, and the clear fires on the cycle both halves have been seen.
// A halt request always clears. Disabled: nothing clears, nothing pends.
// Assumes: strobes are synchronous to clk and one cycle wide.
module wdog_clear_ctl
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  clr_policy_e policy,
    input  logic        halt_req,
    input  logic        clr_one,
    input  logic        clr_a,
    input  logic        clr_b,
    output logic        wd_clear
);

    logic pend_a_q;
    logic pend_b_q;
    logic seen_a;
    logic seen_b;
    logic paired;
    logic sw_clear;

    assign seen_a   = pend_a_q | clr_a;
    assign seen_b   = pend_b_q | clr_b;
    assign paired   = (policy == POLICY_PAIR);
    assign sw_clear = paired ? (seen_a & seen_b) : clr_one;
    assign wd_clear = enable & (halt_req | sw_clear);

    // Pending halves of the paired clear; dropped when any clear applies.
    always_ff @(posedge clk) begin
        if (!rst_n || wd_clear) begin
            pend_a_q <= 1'b0;
            pend_b_q <= 1'b0;
        end else if (enable && paired) begin
            pend_a_q <= seen_a;
            pend_b_q <= seen_b;
        end
    end

    // R6: once a clear is applied, no half remains pending.
    p_pend_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_clear |=> (!pend_a_q && !pend_b_q));

    // R6: a recorded half stays recorded until a clear is applied.
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_a_q && !wd_clear) |=> pend_a_q);

    // R5: the single policy never records pair halves.
    p_single_no_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POLICY_SINGLE) |=> (!pend_a_q && !pend_b_q));

endmodule

// File: rtl/wdog_chain.sv
// Base counter followed by the prescaler. The selected tap flags an
// overflow on the tick that completes 2**(BASE_BITS+sel) ticks. The
// overflow and any clear both restart the whole chain from zero.
// Assumes: SEL_BITS can address all PRE_BITS+1 taps.
module wdog_chain #(
    parameter int BASE_BITS = 8,
    parameter int PRE_BITS  = 7,
    parameter int SEL_BITS  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wd_clear,
    input  logic [SEL_BITS-1:0] sel,
    output logic                ovf
);

    localparam int NTAPS = PRE_BITS + 1;

    logic [BASE_BITS-1:0] base_q;
    logic [PRE_BITS-1:0]  pre_q;
    logic [NTAPS-1:0]     tap_full;
    logic                 base_full;

    assign base_full   = &base_q;
    assign tap_full[0] = 1'b1;

    // Tap i is full when prescaler bits below i are all ones.
    for (genvar i = 0; i < PRE_BITS; i++) begin : g_tap
        assign tap_full[i+1] = tap_full[i] & pre_q[i];
    end

    assign ovf = tick & base_full & tap_full[sel];

    // Advance the base counter and ripple into the prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n || wd_clear || ovf) begin
            base_q <= '0;
            pre_q  <= '0;
        end else if (tick) begin
            base_q <= base_q + 1'b1;
            if (base_full) begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R9: the chain restarts from zero after an overflow or a clear.
    p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf || wd_clear) |=> (base_q == '0 && pre_q == '0));

    // R8: without a tick, clear or overflow the count holds.
    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wd_clear) |=> ($stable(base_q) && $stable(pre_q)));

endmodule

// File: rtl/wdog_timer.sv
// Watchdog top: control register, tick source, clear policy, counter chain
// and registered expiry outputs split by the halted state.
// Assumes: opt_* straps change only while rst_n is low.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int BASE_BITS   = 8,
    parameter int PRE_BITS    = 7,
    parameter int REG_BITS    = 8,
    parameter int DIV_BITS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                opt_enable,
    input  logic                opt_osc_src,
    input  logic                opt_dual_clr,
    input  logic                osc_raw,
    input  logic                halt_req,
    input  logic                halted,
    input  logic                clr_one,
    input  logic                clr_a,
    input  logic                clr_b,
    input  logic                reg_we,
    input  logic [REG_BITS-1:0] reg_wdata,
    output logic [REG_BITS-1:0] reg_rdata,
    output logic                to_cold,
    output logic                to_warm
);

    localparam int SEL_BITS = $clog2(PRE_BITS + 1);
    localparam logic [REG_BITS-1:0] REG_RESET = REG_BITS'((1 << SEL_BITS) - 1);

    logic [REG_BITS-1:0] ctrl_q;
    tick_src_e           src;
    clr_policy_e         policy;
    logic                tick;
    logic                wd_clear;
    logic                ovf;
    logic                expire;

    assign src    = opt_osc_src  ? SRC_OSC     : SRC_INSTR;
    assign policy = opt_dual_clr ? POLICY_PAIR : POLICY_SINGLE;

    // Control register: low bits pick the tap, upper bits are plain flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= REG_RESET;
        end else if (reg_we) begin
            ctrl_q <= reg_wdata;
        end
    end

    assign reg_rdata = ctrl_q;

    wdog_tick_gen #(
        .DIV_BITS    (DIV_BITS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (opt_enable),
        .src      (src),
        .halted   (halted),
        .wd_clear (wd_clear),
        .osc_raw  (osc_raw),
        .tick     (tick)
    );

    wdog_clear_ctl u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (opt_enable),
        .policy   (policy),
        .halt_req (halt_req),
        .clr_one  (clr_one),
        .clr_a    (clr_a),
        .clr_b    (clr_b),
        .wd_clear (wd_clear)
    );

    wdog_chain #(
        .BASE_BITS (BASE_BITS),
        .PRE_BITS  (PRE_BITS),
        .SEL_BITS  (SEL_BITS)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wd_clear (wd_clear),
        .sel      (ctrl_q[SEL_BITS-1:0]),
        .ovf      (ovf)
    );

    // A clear in the same cycle as the overflow wins.
    assign expire = ovf & ~wd_clear;

    // Register the expiry, routed by the halted state at the expiring tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_cold <= 1'b0;
            to_warm <= 1'b0;
        end else begin
            to_cold <= expire & ~halted;
            to_warm <= expire & halted;
        end
    end

    // R9: each expiry lasts exactly one cycle.
    p_expiry_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (to_cold || to_warm) |=> (!to_cold && !to_warm));

    // R9: an expiry never appears on both outputs.
    p_expiry_one_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({to_cold, to_warm}));

    // R10: a disabled watchdog never expires.
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_enable |=> (!to_cold && !to_warm));

    // R4: the register holds its value between writes.
    p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(ctrl_q));

endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;

    localparam int B     = 2;
    localparam int LIMIT = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opt_enable = 1'b1;
    logic       opt_osc_src = 1'b0;
    logic       opt_dual_clr = 1'b0;
    logic       osc_raw = 1'b0;
    logic       halt_req = 1'b0;
    logic       halted = 1'b0;
    logic       clr_one = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       to_cold;
    logic       to_warm;

    int errors = 0;
    int checks = 0;
    bit seen_cold;
    bit seen_warm;

    always #2 clk = ~clk;

    wdog_timer #(.BASE_BITS(B)) u_wdog_timer (
        .clk(clk), .rst_n(rst_n), .opt_enable(opt_enable),
        .opt_osc_src(opt_osc_src), .opt_dual_clr(opt_dual_clr),
        .osc_raw(osc_raw), .halt_req(halt_req), .halted(halted),
        .clr_one(clr_one), .clr_a(clr_a), .clr_b(clr_b),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .to_cold(to_cold), .to_warm(to_warm)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (to_cold) seen_cold = 1'b1;
        if (to_warm) seen_warm = 1'b1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: clr_one = 1'b1;
            1: clr_a = 1'b1;
            2: clr_b = 1'b1;
            3: begin clr_a = 1'b1; clr_b = 1'b1; end
            default: halt_req = 1'b1;
        endcase
        step();
        {clr_one, clr_a, clr_b, halt_req} = '0;
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        step();
        reg_we = 1'b0;
    endtask

    task automatic restart(input bit en, input bit osc, input bit dual);
        @(negedge clk);
        rst_n = 1'b0;
        opt_enable = en;
        opt_osc_src = osc;
        opt_dual_clr = dual;
        halted = 1'b0;
        osc_raw = 1'b0;
        run(3);
        @(negedge clk);
        rst_n = 1'b1;
        step();
    endtask

    // Count edges until an expiry is seen.
    task automatic measure(output int n);
        n = 0;
        seen_cold = 1'b0;
        seen_warm = 1'b0;
        while (!(seen_cold || seen_warm) && n < LIMIT) begin
            step();
            n++;
        end
    endtask

    task automatic osc_pulse();
        @(negedge clk);
        osc_raw = 1'b1;
        run(4);
        @(negedge clk);
        osc_raw = 1'b0;
        run(4);
    endtask

    initial begin
        #600000;
        errors++;
        checks++;
        $display("FAIL watchdog timer expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int t;
        logic [7:0] v;

        run(3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(reg_rdata == 8'h07, "R1 reset register", reg_rdata, 8'h07);
        check(!to_cold && !to_warm, "R1 reset outputs", {to_cold, to_warm}, 0);

        // R2, R4, R9: instruction-rate sweep over every tap.
        for (int k = 0; k < 8; k++) begin
            v = 8'((k * 8'd37) & 8'hF8) | 8'(k);
            write_reg(v);
            check(reg_rdata == v, "R4 readback", reg_rdata, v);
            t = 4 * (1 << (B + k));
            strobe(0);
            measure(n);
            check(n == t, "R2 instr period", n, t);
            check(seen_cold && !seen_warm, "R9 cold side", {seen_warm, seen_cold}, 1);
            measure(n);
            check(n == t, "R9 restart period", n, t);
        end

        // R5: single policy ignores pair strobes.
        write_reg(8'h03);
        strobe(0);
        run(40);
        strobe(1);
        strobe(2);
        measure(n);
        check(n == 128 - 42, "R5 pair ignored", n, 86);
        strobe(0);
        run(50);
        strobe(0);
        measure(n);
        check(n == 128, "R5 single clear", n, 128);

        // R7: halt request clears.
        strobe(0);
        run(50);
        strobe(4);
        measure(n);
        check(n == 128, "R7 halt clear", n, 128);

        // R8: halted freezes the instruction-rate count.
        write_reg(8'h05);
        strobe(0);
        run(100);
        @(negedge clk);
        halted = 1'b1;
        seen_cold = 1'b0;
        seen_warm = 1'b0;
        run(2000);
        check(!seen_cold && !seen_warm, "R8 frozen no expiry", {seen_warm, seen_cold}, 0);
        @(negedge clk);
        halted = 1'b0;
        measure(n);
        check(n == 512 - 100, "R8 resume remainder", n, 412);

        // R6: paired policy.
        restart(1'b1, 1'b0, 1'b1);
        write_reg(8'h03);
        strobe(3);
        run(30);
        strobe(0);
        strobe(1);
        measure(n);
        check(n == 128 - 32, "R6 lone half ignored", n, 96);
        strobe(2);
        measure(n);
        check(n == 128, "R6 pending across expiry", n, 128);
        strobe(2);
        run(20);
        strobe(1);
        measure(n);
        check(n == 128, "R6 b then a", n, 128);
        strobe(3);
        run(10);
        strobe(4);
        measure(n);
        check(n == 128, "R7 halt clear paired", n, 128);

        // R3, R8, R9: oscillator sweep, halted on odd codes.
        restart(1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 8; k++) begin
            write_reg(8'(k));
            @(negedge clk);
            halted = k[0];
            strobe(0);
            t = 1 << (B + k);
            n = 0;
            seen_cold = 1'b0;
            seen_warm = 1'b0;
            while (!(seen_cold || seen_warm) && n < 1000) begin
                osc_pulse();
                n++;
            end
            check(n == t, "R3 osc pulses", n, t);
            if (k[0]) begin
                check(seen_warm && !seen_cold, "R9 warm side R8 osc runs halted",
                      {seen_warm, seen_cold}, 2);
            end else begin
                check(seen_cold && !seen_warm, "R9 cold side osc",
                      {seen_warm, seen_cold}, 1);
            end
        end
        @(negedge clk);
        halted = 1'b0;

        // R10: disabled watchdog.
        restart(1'b0, 1'b0, 1'b0);
        write_reg(8'h00);
        seen_cold = 1'b0;
        seen_warm = 1'b0;
        run(300);
        strobe(0);
        strobe(4);
        run(200);
        check(!seen_cold && !seen_warm, "R10 instr disabled", {seen_warm, seen_cold}, 0);
        write_reg(8'h5A);
        check(reg_rdata == 8'h5A, "R10 register usable", reg_rdata, 8'h5A);
        restart(1'b0, 1'b1, 1'b1);
        write_reg(8'h00);
        seen_cold = 1'b0;
        seen_warm = 1'b0;
        for (int i = 0; i < 20; i++) osc_pulse();
        strobe(3);
        for (int i = 0; i < 10; i++) osc_pulse();
        check(!seen_cold && !seen_warm, "R10 osc disabled", {seen_warm, seen_cold}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule